// File: doc/BRIEF.md
# Time-Bin and Time-Tag Acquisition Controller

This controller sits between a timing front end and a dual-ported acquisition memory. The front end delivers one-cycle START and STOP strobes together with a fine time value, which is the time elapsed since the front-end timer was last cleared, and a channel number. Depending on a static mode, the controller turns accepted STOP events into one of two kinds of memory traffic. In the histogram modes, the measured time selects a bin and that bin is read, incremented and written back. In the FIFO modes, one or two time-tag words are appended at a write pointer that wraps around.

Four acquisition policies are available: single-stop histogram, multi-stop histogram, single-stop FIFO with macro time, and multi-stop FIFO tagging. The multi-stop FIFO policy runs either free (only the first START counts) or resynchronised (every START counts). The controller drives a timer-clear pulse back to the front end. It counts STOP events that it had to discard because a memory operation was still in progress. The memory is word addressed, accepts a write or a read in any cycle, and returns read data in the cycle after the read strobe. Mode, resync option and bin depth are set while reset is asserted and are held stable afterwards.

Top module: `acq_tagger`

## Requirements
- R1: While reset is asserted and in the first cycle after it, memRd, memWr and timerRst are low and dropCnt is zero.
- R2: Mode 0 (single-stop histogram): a STOP is measured only after a START and before the next measured STOP. START and each measured STOP each give a one-cycle timerRst pulse in the next cycle. A STOP with no pending START writes nothing.
- R3: Mode 1 (multi-stop histogram): every STOP after a START increments its bin. STOPs give no timerRst pulse and only a START does.
- R4: A histogram increment for a STOP sampled on clock edge k reads the bin on memRd at edge k+1 and writes it on memWr at edge k+2 to the same address. The bin address is the fine time shifted right by BIN_SHIFT (default 0), taken modulo the memory depth.
- R5: The bin increment saturates. With wideBins=0 the count lives in bits 15:0, saturates at 0xFFFF, and bits 31:16 are written as zero. With wideBins=1 the count is 32 bits wide and saturates at 0xFFFFFFFF.
- R6: Mode 2 (single-stop FIFO): each measured STOP writes one word at edge k+1. Bits 15:0 of the word hold the fine time, and bits 31:16 hold the low 16 bits of a macro-time counter that advances once per clock. Further STOPs are ignored until the next START.
- R7: Mode 3 (multi-stop FIFO): each STOP after the run has started writes two words at consecutive addresses on edges k+1 and k+2. The first word holds the fine time in bits 15:0 and the channel in bits 17:16. The second word holds the full 32-bit macro time.
- R8: Mode 3 with resyncEn=0: only the first START after reset gives a timerRst pulse. Later STARTs change nothing, and every STOP after the first START is tagged.
- R9: Mode 3 with resyncEn=1: every START gives a timerRst pulse.
- R10: FIFO words go to consecutive addresses starting at 0 after reset. After the last address, writing continues at address 0 while stopCmd is low.
- R11: If stopCmd is high when a FIFO word is written to the last address, no further FIFO words are written until reset, and the STOPs involved are not counted as dropped.
- R12: A STOP that would be measured while a memory operation is in progress is not written and not queued. Instead it increments dropCnt, which saturates at its maximum value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeSel | input | 2 | 0 single-stop histogram, 1 multi-stop histogram, 2 single-stop FIFO, 3 multi-stop FIFO |
| resyncEn | input | 1 | Mode 3: every START re-synchronises |
| wideBins | input | 1 | 1: 32-bit bins, 0: 16-bit bins |
| stopCmd | input | 1 | Halt FIFO writing at the end of memory |
| startEvt | input | 1 | START event strobe |
| stopEvt | input | 1 | STOP event strobe |
| fineTime | input | FINE_W | Fine time since the last timer clear |
| chanId | input | CH_W | Channel number of the event |
| timerRst | output | 1 | One-cycle clear request to the front-end timer |
| memRd | output | 1 | Memory read strobe |
| memWr | output | 1 | Memory write strobe |
| memAddr | output | ADDR_W | Memory word address |
| memWdata | output | 32 | Memory write data |
| memRdata | input | 32 | Memory read data, valid the cycle after memRd |
| dropCnt | output | DROP_W | Saturating count of dropped STOP events |

## Verification
A wrong armed or started flag shows up within two edges as a missing or extra memRd/memWr, or as a timerRst pulse where none is expected. The write log and the pulse count expose it directly. A wrong phase sequence is caught on the next increment: the write is not one edge behind the read, or the address differs. A faulty pointer or halt flag shows as an address that is not consecutive, or as a write after the halt at the last address. A faulty macro counter shows as a difference between two tags that does not equal the number of cycles between them.

// File: rtl/acq_pkg.sv
package acq_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    MODE_HIST_SINGLE = 2'd0,
    MODE_HIST_MULTI  = 2'd1,
    MODE_FIFO_SINGLE = 2'd2,
    MODE_FIFO_MULTI  = 2'd3
  } acqMode_e;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_READ   = 3'd1,
    PH_BUMP   = 3'd2,
    PH_TAG    = 3'd3,
    PH_TAG_LO = 3'd4,
    PH_TAG_HI = 3'd5
  } phase_e;

  typedef struct packed {
    phase_e phase;
    logic   capture;
    logic   dropInc;
    logic   rstTimer;
  } strobe_t;
endpackage

// File: rtl/acq_ctrl.sv
module acq_ctrl
  import acq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  acqMode_e mode,
  input  logic     resyncEn,
  input  logic     startEvt,
  input  logic     stopEvt,
  input  logic     fifoHalted,
  output strobe_t  ctl
);
  phase_e phase, phaseNext;
  logic   armed, everStarted, rstTimerQ;
  logic   fifoMode, singleStop, startTakes, stopWanted, busy, stopTake, stopDrop;

  assign fifoMode   = mode[1];
  assign singleStop = (mode == MODE_HIST_SINGLE) || (mode == MODE_FIFO_SINGLE);
  assign busy       = (phase != PH_IDLE);

  // A free-running tag run honours only its very first START.
  assign startTakes = startEvt &&
                      !((mode == MODE_FIFO_MULTI) && !resyncEn && everStarted);
  assign stopWanted = stopEvt && armed && !(fifoMode && fifoHalted);
  assign stopTake   = stopWanted && !busy;
  assign stopDrop   = stopWanted && busy;

  always_comb begin
    phaseNext = phase;
    unique case (phase)
      PH_IDLE: if (stopTake) begin
        unique case (mode)
          MODE_HIST_SINGLE, MODE_HIST_MULTI: phaseNext = PH_READ;
          MODE_FIFO_SINGLE:                  phaseNext = PH_TAG;
          default:                           phaseNext = PH_TAG_LO;
        endcase
      end
      PH_READ:   phaseNext = PH_BUMP;
      PH_TAG_LO: phaseNext = PH_TAG_HI;
      default:   phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase       <= PH_IDLE;
      armed       <= 1'b0;
      everStarted <= 1'b0;
      rstTimerQ   <= 1'b0;
    end else begin
      phase     <= phaseNext;
      rstTimerQ <= startTakes || (stopTake && singleStop);
      if (startTakes) begin
        armed       <= 1'b1;
        everStarted <= 1'b1;
      end else if (stopTake && singleStop) begin
        armed <= 1'b0;
      end
    end
  end

  always_comb begin
    ctl.phase    = phase;
    ctl.capture  = stopTake;
    ctl.dropInc  = stopDrop;
    ctl.rstTimer = rstTimerQ;
  end
endmodule

// File: rtl/acq_datapath.sv
module acq_datapath
  import acq_pkg::*;
#(
  parameter int FINE_W    = 16,
  parameter int CH_W      = 2,
  parameter int ADDR_W    = 8,
  parameter int DROP_W    = 8,
  parameter int BIN_SHIFT = 0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wideBins,
  input  logic                stopCmd,
  input  logic [FINE_W-1:0]   fineTime,
  input  logic [CH_W-1:0]     chanId,
  input  strobe_t             ctl,
  input  logic [WORD_W-1:0]   memRdata,
  output logic                memRd,
  output logic                memWr,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [WORD_W-1:0]   memWdata,
  output logic                fifoHalted,
  output logic [DROP_W-1:0]   dropCnt
);
  localparam int HALF_W   = WORD_W / 2;
  localparam int MACRO_LO = WORD_W - FINE_W;
  localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

  logic [WORD_W-1:0] macroCnt, capMacro;
  logic [FINE_W-1:0] capFine;
  logic [CH_W-1:0]   capChan;
  logic [ADDR_W-1:0] wrPtr, binAddr;
  logic [HALF_W-1:0] narrowCnt, narrowNext;
  logic [WORD_W-1:0] wideNext, bumpVal, wordSingle, wordLo, wordHi;
  logic              tagWrite;

  assign binAddr = ADDR_W'(capFine >> BIN_SHIFT);

  // Saturating increment for both bin depths.
  assign narrowCnt  = memRdata[HALF_W-1:0];
  assign narrowNext = (narrowCnt == '1) ? narrowCnt : narrowCnt + 1'b1;
  assign wideNext   = (memRdata == '1) ? memRdata : memRdata + 1'b1;
  assign bumpVal    = wideBins ? wideNext : {{(WORD_W-HALF_W){1'b0}}, narrowNext};

  assign wordSingle = {capMacro[MACRO_LO-1:0], capFine};
  assign wordLo     = WORD_W'({capChan, capFine});
  assign wordHi     = capMacro;

  assign tagWrite = (ctl.phase == PH_TAG) || (ctl.phase == PH_TAG_LO) ||
                    (ctl.phase == PH_TAG_HI);

  always_comb begin
    memRd    = 1'b0;
    memWr    = 1'b0;
    memAddr  = wrPtr;
    memWdata = '0;
    unique case (ctl.phase)
      PH_READ:   begin memRd = 1'b1; memAddr = binAddr; end
      PH_BUMP:   begin memWr = 1'b1; memAddr = binAddr; memWdata = bumpVal; end
      PH_TAG:    begin memWr = 1'b1; memWdata = wordSingle; end
      PH_TAG_LO: begin memWr = 1'b1; memWdata = wordLo; end
      PH_TAG_HI: begin memWr = 1'b1; memWdata = wordHi; end
      default:   ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      macroCnt   <= '0;
      capMacro   <= '0;
      capFine    <= '0;
      capChan    <= '0;
      wrPtr      <= '0;
      fifoHalted <= 1'b0;
      dropCnt    <= '0;
    end else begin
      macroCnt <= macroCnt + 1'b1;
      if (ctl.capture) begin
        capFine  <= fineTime;
        capChan  <= chanId;
        capMacro <= macroCnt;
      end
      if (tagWrite) begin
        wrPtr <= wrPtr + 1'b1;
        if (stopCmd && (wrPtr == LAST_ADDR)) fifoHalted <= 1'b1;
      end
      if (ctl.dropInc && (dropCnt != '1)) dropCnt <= dropCnt + 1'b1;
    end
  end
endmodule

// File: rtl/acq_tagger.sv
module acq_tagger
  import acq_pkg::*;
#(
  parameter int FINE_W    = 16,
  parameter int CH_W      = 2,
  parameter int ADDR_W    = 8,
  parameter int DROP_W    = 8,
  parameter int BIN_SHIFT = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        modeSel,
  input  logic              resyncEn,
  input  logic              wideBins,
  input  logic              stopCmd,
  input  logic              startEvt,
  input  logic              stopEvt,
  input  logic [FINE_W-1:0] fineTime,
  input  logic [CH_W-1:0]   chanId,
  output logic              timerRst,
  output logic              memRd,
  output logic              memWr,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  input  logic [31:0]       memRdata,
  output logic [DROP_W-1:0] dropCnt
);
  strobe_t ctl;
  logic    fifoHalted;

  acq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .mode       (acqMode_e'(modeSel)),
    .resyncEn   (resyncEn),
    .startEvt   (startEvt),
    .stopEvt    (stopEvt),
    .fifoHalted (fifoHalted),
    .ctl        (ctl)
  );

  acq_datapath #(
    .FINE_W(FINE_W), .CH_W(CH_W), .ADDR_W(ADDR_W),
    .DROP_W(DROP_W), .BIN_SHIFT(BIN_SHIFT)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .wideBins   (wideBins),
    .stopCmd    (stopCmd),
    .fineTime   (fineTime),
    .chanId     (chanId),
    .ctl        (ctl),
    .memRdata   (memRdata),
    .memRd      (memRd),
    .memWr      (memWr),
    .memAddr    (memAddr),
    .memWdata   (memWdata),
    .fifoHalted (fifoHalted),
    .dropCnt    (dropCnt)
  );

  assign timerRst = ctl.rstTimer;
endmodule

// File: rtl/acq_tagger_chk.sv
module acq_tagger_chk #(
  parameter int ADDR_W = 8,
  parameter int DROP_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        modeSel,
  input logic              wideBins,
  input logic              stopCmd,
  input logic              startEvt,
  input logic              stopEvt,
  input logic              timerRst,
  input logic              memRd,
  input logic              memWr,
  input logic [ADDR_W-1:0] memAddr,
  input logic [31:0]       memWdata,
  input logic [DROP_W-1:0] dropCnt
);
  logic              seenTag, haltSeen;
  logic [ADDR_W-1:0] lastTagAddr;
  logic              tagWr;

  assign tagWr = memWr && modeSel[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seenTag     <= 1'b0;
      haltSeen    <= 1'b0;
      lastTagAddr <= '0;
    end else if (tagWr) begin
      seenTag     <= 1'b1;
      lastTagAddr <= memAddr;
      if (stopCmd && (memAddr == '1)) haltSeen <= 1'b1;
    end
  end

  assert_rst_quiet_R1: assert property (@(posedge clk)
    !rstN |=> !memRd && !memWr && !timerRst && (dropCnt == '0));

  assert_timer_cause_R2: assert property (@(posedge clk) disable iff (!rstN)
    timerRst |-> $past(startEvt || stopEvt));

  assert_no_rd_wr_clash_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && memWr));

  assert_bump_follows_read_R4: assert property (@(posedge clk) disable iff (!rstN)
    (memWr && !modeSel[1]) |-> ($past(memRd) && (memAddr == $past(memAddr))));

  assert_bin_no_wrap_R5: assert property (@(posedge clk) disable iff (!rstN)
    (memWr && !modeSel[1]) |-> ((memWdata != '0) && (wideBins || (memWdata[31:16] == '0))));

  assert_fifo_consecutive_R10: assert property (@(posedge clk) disable iff (!rstN)
    (tagWr && seenTag) |-> (memAddr == ADDR_W'(lastTagAddr + 1'b1)));

  assert_halt_holds_R11: assert property (@(posedge clk) disable iff (!rstN)
    haltSeen |-> !tagWr);

  assert_drop_monotonic_R12: assert property (@(posedge clk) disable iff (!rstN)
    dropCnt >= $past(dropCnt));
endmodule

bind acq_tagger acq_tagger_chk #(.ADDR_W(ADDR_W), .DROP_W(DROP_W)) u_chk (
  .clk(clk), .rstN(rstN), .modeSel(modeSel), .wideBins(wideBins),
  .stopCmd(stopCmd), .startEvt(startEvt), .stopEvt(stopEvt),
  .timerRst(timerRst), .memRd(memRd), .memWr(memWr), .memAddr(memAddr),
  .memWdata(memWdata), .dropCnt(dropCnt)
);

// File: tb/tb_acq_tagger.sv
`timescale 1ns/1ps
module tb_acq_tagger;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  modeSel = 2'd0;
  logic        resyncEn = 1'b0, wideBins = 1'b0, stopCmd = 1'b0;
  logic        startEvt = 1'b0, stopEvt = 1'b0;
  logic [15:0] fineTime = '0;
  logic [1:0]  chanId = '0;
  logic        timerRst, memRd, memWr;
  logic [7:0]  memAddr;
  logic [31:0] memWdata, memRdata;
  logic [7:0]  dropCnt;

  acq_tagger dut (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .resyncEn(resyncEn),
    .wideBins(wideBins), .stopCmd(stopCmd), .startEvt(startEvt),
    .stopEvt(stopEvt), .fineTime(fineTime), .chanId(chanId),
    .timerRst(timerRst), .memRd(memRd), .memWr(memWr), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .dropCnt(dropCnt)
  );

  always #10 clk = ~clk;

  int total = 0, bad = 0;
  int cyc = 0;
  int wrN = 0, rdN = 0, trN = 0, lastRdCyc = 0;
  logic [31:0] mem [256];
  logic [7:0]  wrAddrLog [512];
  logic [31:0] wrDataLog [512];
  int          wrCycLog  [512];
  logic        pokeEn = 1'b0;
  logic [7:0]  pokeAddr = '0;
  logic [31:0] pokeData = '0;
  logic [31:0] rdReg = '0;

  assign memRdata = rdReg;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rstN) begin
      for (int i = 0; i < 256; i++) mem[i] <= '0;
      wrN <= 0; rdN <= 0; trN <= 0;
    end else begin
      if (pokeEn) mem[pokeAddr] <= pokeData;
      if (memWr) begin
        mem[memAddr] <= memWdata;
        if (wrN < 512) begin
          wrAddrLog[wrN] <= memAddr;
          wrDataLog[wrN] <= memWdata;
          wrCycLog[wrN]  <= cyc;
        end
        wrN <= wrN + 1;
      end
      if (memRd) begin
        rdReg     <= mem[memAddr];
        lastRdCyc <= cyc;
        rdN       <= rdN + 1;
      end
      if (timerRst) trN <= trN + 1;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic doReset(input logic [1:0] m, input logic rs, input logic wb, input logic sc);
    @(negedge clk);
    rstN = 1'b0; modeSel = m; resyncEn = rs; wideBins = wb; stopCmd = sc;
    startEvt = 1'b0; stopEvt = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic pulseStart();
    @(negedge clk); startEvt = 1'b1;
    @(posedge clk); #1 startEvt = 1'b0;
  endtask

  task automatic pulseStop(input logic [15:0] f, input logic [1:0] ch, output int k);
    @(negedge clk); stopEvt = 1'b1; fineTime = f; chanId = ch; k = cyc;
    @(posedge clk); #1 stopEvt = 1'b0;
  endtask

  task automatic poke(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); pokeEn = 1'b1; pokeAddr = a; pokeData = d;
    @(negedge clk); pokeEn = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic testReset();
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk);
    check(!memRd && !memWr && !timerRst, "R1 strobes in reset", {memRd, memWr, timerRst}, 0);
    check(dropCnt == 0, "R1 dropCnt in reset", dropCnt, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!memRd && !memWr && !timerRst, "R1 strobes after reset", {memRd, memWr, timerRst}, 0);
  endtask

  task automatic testHistSingle();
    int k;
    doReset(2'd0, 1'b0, 1'b0, 1'b0);
    pulseStop(16'd5, 2'd0, k); settle();
    check(wrN == 0, "R2 stop before start ignored", wrN, 0);
    check(trN == 0, "R2 no timer clear without start", trN, 0);
    pulseStart();
    pulseStop(16'd5, 2'd0, k); settle();
    check(lastRdCyc == k + 1, "R4 read one edge after stop", lastRdCyc, k + 1);
    check(wrN == 1 && wrCycLog[0] == k + 2, "R4 write one edge after read", wrCycLog[0], k + 2);
    check(wrAddrLog[0] == 8'd5 && mem[5] == 32'd1, "R4 bin 5 incremented", mem[5], 1);
    pulseStop(16'd7, 2'd0, k); settle();
    check(mem[7] == 32'd0 && wrN == 1, "R2 second stop ignored", mem[7], 0);
    pulseStart();
    pulseStop(16'd5, 2'd0, k); settle();
    check(mem[5] == 32'd2, "R2 bin 5 counts again", mem[5], 2);
    check(trN == 4, "R2 timer clears on start and stop", trN, 4);
  endtask

  task automatic testHistMulti();
    int k;
    doReset(2'd1, 1'b0, 1'b0, 1'b0);
    pulseStart();
    pulseStop(16'd3, 2'd0, k); settle();
    pulseStop(16'd3, 2'd0, k); settle();
    pulseStop(16'd9, 2'd0, k); settle();
    check(mem[3] == 32'd2, "R3 bin 3 counts every stop", mem[3], 2);
    check(mem[9] == 32'd1, "R3 bin 9 counted", mem[9], 1);
    check(trN == 1, "R3 stops do not clear timer", trN, 1);
    pulseStart(); settle();
    check(trN == 2, "R3 start clears timer", trN, 2);
  endtask

  task automatic testSaturate();
    int k;
    doReset(2'd0, 1'b0, 1'b0, 1'b0);
    poke(8'd4, 32'h0000_FFFF);
    poke(8'd6, 32'h1234_FFFE);
    pulseStart(); pulseStop(16'd4, 2'd0, k); settle();
    pulseStart(); pulseStop(16'd6, 2'd0, k); settle();
    check(mem[4] == 32'h0000_FFFF, "R5 16-bit bin saturates", mem[4], 32'h0000_FFFF);
    check(mem[6] == 32'h0000_FFFF, "R5 16-bit bin clears upper half", mem[6], 32'h0000_FFFF);
    doReset(2'd0, 1'b0, 1'b1, 1'b0);
    poke(8'd4, 32'hFFFF_FFFF);
    poke(8'd6, 32'h0001_FFFF);
    pulseStart(); pulseStop(16'd4, 2'd0, k); settle();
    pulseStart(); pulseStop(16'd6, 2'd0, k); settle();
    check(mem[4] == 32'hFFFF_FFFF, "R5 32-bit bin saturates", mem[4], 32'hFFFF_FFFF);
    check(mem[6] == 32'h0002_0000, "R5 32-bit bin carries", mem[6], 32'h0002_0000);
  endtask

  task automatic testFifoSingle();
    int k1, k2, k;
    doReset(2'd2, 1'b0, 1'b0, 1'b0);
    pulseStop(16'h0042, 2'd0, k); settle();
    check(wrN == 0, "R6 stop before start ignored", wrN, 0);
    pulseStart();
    pulseStop(16'h0123, 2'd0, k1);
    pulseStop(16'h0456, 2'd0, k); settle();
    repeat (5) @(negedge clk);
    pulseStart();
    pulseStop(16'h0777, 2'd0, k2); settle();
    check(wrN == 2, "R6 one word per measured stop", wrN, 2);
    check(wrCycLog[0] == k1 + 1, "R6 word written one edge after stop", wrCycLog[0], k1 + 1);
    check(wrAddrLog[0] == 0 && wrAddrLog[1] == 1, "R6 consecutive addresses", wrAddrLog[1], 1);
    check(wrDataLog[0][15:0] == 16'h0123 && wrDataLog[1][15:0] == 16'h0777,
          "R6 fine time field", wrDataLog[1][15:0], 16'h0777);
    check(16'(wrDataLog[1][31:16] - wrDataLog[0][31:16]) == 16'(k2 - k1),
          "R6 macro field tracks cycles", 16'(wrDataLog[1][31:16] - wrDataLog[0][31:16]), 16'(k2 - k1));
  endtask

  task automatic testFifoMultiFree();
    int k1, k2, k;
    doReset(2'd3, 1'b0, 1'b0, 1'b0);
    pulseStop(16'h0099, 2'd2, k); settle();
    check(wrN == 0, "R8 stop before first start ignored", wrN, 0);
    pulseStart(); settle();
    pulseStop(16'h0011, 2'd1, k1); settle();
    pulseStart(); pulseStart(); settle();
    check(trN == 1, "R8 later starts ignored", trN, 1);
    pulseStop(16'h0022, 2'd3, k2); settle();
    check(wrN == 4, "R7 two words per tag", wrN, 4);
    check(wrCycLog[0] == k1 + 1 && wrCycLog[1] == k1 + 2, "R7 word timing", wrCycLog[1], k1 + 2);
    check(wrDataLog[0] == 32'h0001_0011, "R7 first word chan and fine", wrDataLog[0], 32'h0001_0011);
    check(wrDataLog[2] == 32'h0003_0022, "R7 third word chan and fine", wrDataLog[2], 32'h0003_0022);
    check(wrDataLog[3] - wrDataLog[1] == 32'(k2 - k1), "R7 macro word difference",
          wrDataLog[3] - wrDataLog[1], k2 - k1);
    check(wrAddrLog[3] == 8'd3, "R7 addresses consecutive", wrAddrLog[3], 3);
  endtask

  task automatic testResync();
    int k;
    doReset(2'd3, 1'b1, 1'b0, 1'b0);
    pulseStart(); pulseStart(); pulseStart(); settle();
    check(trN == 3, "R9 every start clears timer", trN, 3);
    pulseStop(16'h0005, 2'd0, k); settle();
    check(wrN == 2, "R9 stop tagged after resync", wrN, 2);
  endtask

  task automatic testWrap();
    int k;
    doReset(2'd3, 1'b1, 1'b0, 1'b0);
    pulseStart();
    for (int i = 0; i < 130; i++) begin
      pulseStop(16'(i), 2'd0, k);
      repeat (2) @(negedge clk);
    end
    settle();
    check(wrN == 260, "R10 all words written", wrN, 260);
    check(wrAddrLog[255] == 8'd255, "R10 last address used", wrAddrLog[255], 255);
    check(wrAddrLog[256] == 8'd0 && wrAddrLog[257] == 8'd1, "R10 wrap to zero", wrAddrLog[256], 0);
    check(dropCnt == 0, "R12 no drops with spacing", dropCnt, 0);
  endtask

  task automatic testHalt();
    int k;
    doReset(2'd2, 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 259; i++) begin
      pulseStart();
      pulseStop(16'(i), 2'd0, k);
    end
    settle();
    check(wrN == 256, "R11 writing halts at last address", wrN, 256);
    check(wrAddrLog[255] == 8'd255, "R11 last word at end", wrAddrLog[255], 255);
    check(dropCnt == 0, "R11 halted stops not dropped", dropCnt, 0);
  endtask

  task automatic testDrop();
    int k;
    doReset(2'd1, 1'b0, 1'b0, 1'b0);
    pulseStart();
    pulseStop(16'd10, 2'd0, k);
    pulseStop(16'd11, 2'd0, k);
    pulseStop(16'd12, 2'd0, k);
    pulseStop(16'd13, 2'd0, k);
    settle();
    check(mem[10] == 1 && mem[13] == 1, "R12 idle stops counted", {mem[10][7:0], mem[13][7:0]}, 16'h0101);
    check(mem[11] == 0 && mem[12] == 0, "R12 busy stops not written", {mem[11][7:0], mem[12][7:0]}, 0);
    check(dropCnt == 8'd2, "R12 two drops", dropCnt, 2);
    for (int i = 0; i < 200; i++) begin
      pulseStop(16'd20, 2'd0, k);
      pulseStop(16'd20, 2'd0, k);
      pulseStop(16'd20, 2'd0, k);
    end
    settle();
    check(mem[20] == 32'd200, "R12 one accept per burst", mem[20], 200);
    check(dropCnt == 8'hFF, "R12 drop counter saturates", dropCnt, 255);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    testReset();
    testHistSingle();
    testHistMulti();
    testSaturate();
    testFifoSingle();
    testFifoMultiFree();
    testResync();
    testWrap();
    testHalt();
    testDrop();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule